// File: doc/BRIEF.md
# USB bulk IN endpoint controller

This block runs one bulk IN endpoint of a USB device. Software or a DMA engine loads outgoing bytes into a 16-entry transmit queue through a byte-write port. It then strobes end-of-packet together with the length of the packet it has queued. A packet-level engine reports every IN token addressed to the endpoint. For each token the block answers with a one-cycle handshake decision: send data, NAK or STALL. During a data phase the engine pulls bytes one at a time. When the engine is finished it reports whether the host acknowledged the packet.

An 8-bit control/status register shows the outcome. A completion flag validates the error and underrun flags beside it, and the completion flag and the stall flag are cleared by writing 1 to them. While the completion flag is set, every token is NAKed, so software sees each result before the next packet goes out. A service flag, also driven on a DMA request pin, asks for more data whenever the queue is half full or emptier. An interrupt request follows the completion flag when interrupts are enabled.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset the status register reads 0x01, dma_req is 1, and irq and hs_valid are 0.
- R2: The queue holds DEPTH (16) bytes and delivers them in write order. A write while the queue is full is dropped.
- R3: Status bit 0 and dma_req are 1 exactly when the queue holds DEPTH/2 (8) or fewer bytes.
- R4: A token accepted while no data phase is running gets a handshake on the next cycle: hs_valid=1 and hs_code 2'b11 STALL if force-stall is set; otherwise 2'b10 NAK if completion is set; otherwise 2'b01 DATA, and a data phase starts with the length given at the last end-of-packet strobe.
- R5: Issuing STALL sets sent-stall (bit 4) and completion (bit 1).
- R6: xfer_done during a data phase sets completion (bit 1) and ends the phase. Packet-error (bit 2) is set if host_ack was 0 and cleared if it was 1.
- R7: A byte request during a data phase with bytes still owed and an empty queue returns rd_valid=0, and completion then reports underrun (bit 3).
- R8: Writing 1 to bit 1 or bit 4 clears that flag. Bit 5 (force-stall) is read/write. Writes to bits 0, 2, 3, 6 and 7 have no effect, and bits 7:6 read 0.
- R9: When hardware sets completion or sent-stall in the same cycle that software writes 1 to clear it, the flag ends up set.
- R10: Bits 2 and 3 read 0 whenever completion is clear.
- R11: irq is 1 exactly when completion is set and irq_en is 1.
- R12: tx_end is 1 during a data phase once the packet length has been requested. A length of 0 gives tx_end at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_we | input | 1 | Byte write strobe into the transmit queue |
| fifo_wdata | input | 8 | Byte to queue |
| pkt_eop | input | 1 | End-of-packet strobe, latches pkt_len |
| pkt_len | input | 5 | Bytes in the queued packet |
| dma_req | output | 1 | Queue is at or below half full |
| csr_we | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status register write data |
| csr_rdata | output | 8 | Status register contents |
| irq_en | input | 1 | Transmit interrupt enable |
| irq | output | 1 | Interrupt request |
| tok_in | input | 1 | IN token received |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 01 DATA, 10 NAK, 11 STALL |
| rd_req | input | 1 | Engine requests next data byte |
| rd_valid | output | 1 | rd_data holds a queued byte |
| rd_data | output | 8 | Byte to transmit |
| tx_end | output | 1 | All bytes of the packet requested |
| xfer_done | input | 1 | Engine finished the data phase |
| host_ack | input | 1 | Host acknowledged, qualified by xfer_done |

## Verification
The properties assume that the engine raises tok_in only outside a data phase, raises xfer_done only inside one, and pulses rd_req no more than once per cycle. They also assume that pkt_len never exceeds the queue depth. The bench keeps to this. It sends each token only after the previous outcome is recorded, ends every phase with exactly one xfer_done, and issues exactly pkt_len byte requests, one per cycle. It sweeps every fill level from empty to beyond full and every packet length from 0 to 16.

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SVC  = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_we,
  input  logic [DW-1:0] fifo_wdata,
  input  logic          pkt_eop,
  input  logic [CW-1:0] pkt_len,
  output logic          dma_req,
  input  logic          csr_we,
  input  logic [7:0]    csr_wdata,
  output logic [7:0]    csr_rdata,
  input  logic          irq_en,
  output logic          irq,
  input  logic          tok_in,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          tx_end,
  input  logic          xfer_done,
  input  logic          host_ack
);
  localparam logic [1:0] HS_DATA  = 2'b01;
  localparam logic [1:0] HS_NAK   = 2'b10;
  localparam logic [1:0] HS_STALL = 2'b11;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, len_q, remaining;
  logic          active, ur, fst, tpc, tpe, tur, sst;

  wire full   = count == CW'(DEPTH);
  wire empty  = count == '0;
  wire owed   = active && remaining != '0;
  wire push   = fifo_we && !full;
  wire pop    = rd_req && owed && !empty;
  wire ur_ev  = rd_req && owed && empty;
  wire tok_ok = tok_in && !active;
  wire stall  = tok_ok && fst;
  wire start  = tok_ok && !fst && !tpc;
  wire fin    = xfer_done && active;
  wire svc    = count <= CW'(SVC);

  assign dma_req   = svc;
  assign irq       = tpc && irq_en;
  assign tx_end    = active && remaining == '0;
  assign csr_rdata = {2'b00, fst, sst, tur && tpc, tpe && tpc, tpc, svc};

  always_ff @(posedge clk) if (push) mem[wptr] <= fifo_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count    <= count + CW'(push) - CW'(pop);
      rd_valid <= pop;
      if (pop) rd_data <= mem[rptr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; remaining <= '0; active <= 1'b0; ur <= 1'b0;
      hs_valid <= 1'b0; hs_code <= '0;
    end else begin
      hs_valid <= tok_ok;
      if (tok_ok) hs_code <= fst ? HS_STALL : (tpc ? HS_NAK : HS_DATA);
      if (pkt_eop) len_q <= pkt_len;
      if (start) begin
        active    <= 1'b1;
        remaining <= len_q;
        ur        <= 1'b0;
      end else begin
        if (fin) active <= 1'b0;
        if (pop || ur_ev) remaining <= remaining - 1'b1;
        if (ur_ev) ur <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst <= 1'b0; tpc <= 1'b0; tpe <= 1'b0; tur <= 1'b0; sst <= 1'b0;
    end else begin
      if (csr_we) fst <= csr_wdata[5];
      tpc <= stall || fin || (tpc && !(csr_we && csr_wdata[1]));
      sst <= stall || (sst && !(csr_we && csr_wdata[4]));
      if (fin) begin
        tpe <= !host_ack;
        tur <= ur || ur_ev;
      end else if (stall) begin
        tpe <= 1'b0;
        tur <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
module usb_in_ep_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tok_in,
  input logic          xfer_done,
  input logic          host_ack,
  input logic          rd_req,
  input logic          rd_valid,
  input logic          hs_valid,
  input logic [1:0]    hs_code,
  input logic [7:0]    csr_rdata,
  input logic          active,
  input logic          fst,
  input logic          tpc,
  input logic [CW-1:0] count,
  input logic [CW-1:0] remaining
);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R4
  nak_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_in && !active && !fst && tpc |=> hs_valid && hs_code == 2'b10);

  // R5
  stall_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_in && !active && fst |=> hs_code == 2'b11 && csr_rdata[4] && csr_rdata[1]);

  // R6
  no_ack_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && active && !host_ack |=> csr_rdata[2] && csr_rdata[1]);

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && active |=> csr_rdata[1]);

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && active && remaining != '0 && count == '0 |=> !rd_valid);
endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .xfer_done(xfer_done),
  .host_ack(host_ack), .rd_req(rd_req), .rd_valid(rd_valid),
  .hs_valid(hs_valid), .hs_code(hs_code), .csr_rdata(csr_rdata),
  .active(active), .fst(fst), .tpc(tpc), .count(count), .remaining(remaining)
);

// File: tb/test_usb_in_ep_ctrl.sv
module test_usb_in_ep_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_we = 0, pkt_eop = 0, csr_we = 0, irq_en = 0, tok_in = 0;
  logic rd_req = 0, xfer_done = 0, host_ack = 0;
  logic [7:0] fifo_wdata = '0, csr_wdata = '0;
  logic [4:0] pkt_len = '0;
  logic dma_req, irq, hs_valid, rd_valid, tx_end;
  logic [7:0] csr_rdata, rd_data;
  logic [1:0] hs_code;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  usb_in_ep_ctrl i_usb_in_ep_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
    .pkt_eop(pkt_eop), .pkt_len(pkt_len), .dma_req(dma_req),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_en(irq_en), .irq(irq), .tok_in(tok_in), .hs_valid(hs_valid),
    .hs_code(hs_code), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .tx_end(tx_end), .xfer_done(xfer_done),
    .host_ack(host_ack)
  );

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic ck(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    fifo_we = 1; fifo_wdata = b; tick(); fifo_we = 0;
  endtask

  task automatic eop(input int n);
    pkt_eop = 1; pkt_len = 5'(n); tick(); pkt_eop = 0;
  endtask

  task automatic token(input string r, input int exp_code);
    tok_in = 1; tick(); tok_in = 0;
    ck(r, {hs_valid, hs_code}, {1'b1, exp_code[1:0]});
  endtask

  task automatic csr_write(input logic [7:0] v);
    csr_we = 1; csr_wdata = v; tick(); csr_we = 0;
  endtask

  task automatic finish_pkt(input logic ack);
    xfer_done = 1; host_ack = ack; tick(); xfer_done = 0; host_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(); rst_n = 1; tick();
    // R1
    ck("R1 csr", csr_rdata, 8'h01);
    ck("R1 dma", dma_req, 1);
    ck("R1 irq", irq, 0);
    ck("R1 hs", hs_valid, 0);

    // R3 fill sweep to beyond full; R2 extra writes dropped
    for (int k = 0; k < 18; k++) begin
      wr_byte(8'((k * 7 + 3) & 8'hff));
      ck("R3 dma", dma_req, ((k + 1 > 16 ? 16 : k + 1) <= 8) ? 1 : 0);
      ck("R3 svc", csr_rdata[0], ((k + 1 > 16 ? 16 : k + 1) <= 8) ? 1 : 0);
    end
    eop(16);
    token("R4 data", 1);
    for (int i = 0; i < 16; i++) begin
      rd_req = 1; tick(); rd_req = 0;
      ck("R2 valid", rd_valid, 1);
      ck("R2 order", rd_data, (i * 7 + 3) & 8'hff);
    end
    ck("R12 end", tx_end, 1);
    irq_en = 1;
    finish_pkt(1);
    ck("R6 ack csr", csr_rdata, 8'h03);
    ck("R11 irq on", irq, 1);
    irq_en = 0; #1;
    ck("R11 irq off", irq, 0);
    irq_en = 1;
    token("R4 nak", 2);
    csr_write(8'hCE);
    ck("R8 w1c ro", csr_rdata, 8'h01);
    ck("R11 irq clr", irq, 0);

    // R6 R12 every length 0..16
    for (int len = 0; len <= 16; len++) begin
      for (int i = 0; i < len; i++) wr_byte(8'((len * 16 + i) & 8'hff));
      eop(len);
      token("R4 data len", 1);
      ck("R12 start", tx_end, len == 0 ? 1 : 0);
      for (int i = 0; i < len; i++) begin
        rd_req = 1; tick(); rd_req = 0;
        ck("R2 data", rd_data, (len * 16 + i) & 8'hff);
        ck("R12 mid", tx_end, i == len - 1 ? 1 : 0);
      end
      finish_pkt(len[0]);
      ck("R6 status", csr_rdata, len[0] ? 8'h03 : 8'h07);
      csr_write(8'h02);
      ck("R8 clear", csr_rdata, 8'h01);
    end

    // R7 underrun: 3 queued, length 5
    for (int i = 0; i < 3; i++) wr_byte(8'(i + 100));
    eop(5);
    token("R7 data", 1);
    for (int i = 0; i < 5; i++) begin
      rd_req = 1; tick(); rd_req = 0;
      ck("R7 valid", rd_valid, i < 3 ? 1 : 0);
    end
    ck("R7 end", tx_end, 1);
    finish_pkt(1);
    ck("R7 underrun", csr_rdata, 8'h0B);
    csr_write(8'h02);
    ck("R10 masked", csr_rdata, 8'h01);

    // R5 stall
    csr_write(8'h20);
    ck("R8 fst rw", csr_rdata, 8'h21);
    token("R5 stall", 3);
    ck("R5 flags", csr_rdata, 8'h33);
    ck("R11 stall irq", irq, 1);
    // R4 stall over nak; R9 set wins over clear
    tok_in = 1; csr_we = 1; csr_wdata = 8'h32; tick();
    tok_in = 0; csr_we = 0;
    ck("R4 prio", hs_code, 3);
    ck("R9 set wins", csr_rdata, 8'h33);
    csr_write(8'h12);
    ck("R8 clr all", csr_rdata, 8'h01);
    // R9 completion from done vs clear same cycle, error bit from no ack
    wr_byte(8'h5A); eop(1);
    token("R9 data", 1);
    rd_req = 1; tick(); rd_req = 0;
    ck("R9 byte", rd_data, 8'h5A);
    xfer_done = 1; host_ack = 0; csr_we = 1; csr_wdata = 8'h02; tick();
    xfer_done = 0; csr_we = 0;
    ck("R9 done wins", csr_rdata, 8'h07);
    csr_write(8'h02);
    ck("R10 err masked", csr_rdata, 8'h01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule